// File: doc/BRIEF.md
# CAS-before-RAS Refresh Controller

This block keeps DRAM contents alive by issuing refresh cycles of the CAS-before-RAS kind on a schedule set by software. A prescaler divides the clock by 64 or by 512, and an 8-bit interval count of prescaled ticks decides how often a refresh is requested. Every setting comes from one 32-bit global timing word. The block samples that word into an internal register on each clock, and reset clears the register.

A request is kept as a single pending flag. It turns into a refresh only when no normal access is running and the previous refresh, including its precharge, has finished. The refresh raises CAS on every populated bank except the non-volatile bank. RAS follows after a programmable setup time and stays high for a programmable width. RAS and CAS then fall together, and a programmable precharge time follows. A busy flag covers the whole sequence. The access sequencer must treat busy and pending as a reason not to start a new access.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: While the enable bit is set, a refresh request is raised every N×64 clock cycles when timing-word bit 27 is 0, or every N×512 cycles when it is 1. N is the 8-bit interval field in bits 26:19. N = 0 raises no requests.
- R2: The timing word takes effect one clock after it is applied. Reset clears the stored word, so enable (bit 18) reads 0. In the cycle after reset, busy, pending, CAS and RAS are all low. While enable is 0, no request is raised.
- R3: A refresh drives CAS first. RAS rises setup+2 cycles after CAS rises, where setup is bits 31:28. RAS is only ever high on a bank whose CAS is high.
- R4: RAS stays high for minras+1 cycles, where minras is bits 9:5. CAS and RAS fall in the same cycle.
- R5: After RAS and CAS fall, busy stays high for precharge+1 cycles, where precharge is bits 4:0. No refresh starts during that time.
- R6: A refresh starts only in a cycle where acc_active is low. A request raised while an access runs is held on rfr_pending and starts as soon as acc_active falls.
- R7: Refresh drives CAS and RAS only on banks whose bank_en bit is set. The bank at index NVM_BANK (3 by default) is never driven.
- R8: Interval expiries that occur while a request is already pending merge into that request, so exactly one refresh follows.
- R9: rfr_busy is high from the cycle CAS rises to the end of precharge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_cfg | input | 32 | Global timing word (fields as listed in the requirements) |
| bank_en | input | NUM_BANKS | Banks fitted with DRAM |
| acc_active | input | 1 | A normal memory access is in progress |
| rfr_cas | output | NUM_BANKS | Refresh CAS per bank, active high |
| rfr_ras | output | NUM_BANKS | Refresh RAS per bank, active high |
| rfr_busy | output | 1 | Refresh sequence (including precharge) in progress |
| rfr_pending | output | 1 | A refresh request is waiting to start |

## Verification
The bench holds an access active across several interval expiries. A design that queued each expiry would then run a burst of refreshes, and one that dropped the request would run none. It measures the spacing between refreshes under both prescaler settings and with an interval of zero, which catches a swapped divider select or an off-by-one in the interval count. It uses the widest setup, RAS and precharge values, where a wrong offset shows up as a phase that is one cycle long or short. It also uses a bank mask that includes the non-volatile bank, where a missing exclusion would refresh flash.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int PRE_LSB  = 0;
  localparam int PRE_W    = 5;
  localparam int MRAS_LSB = 5;
  localparam int MRAS_W   = 5;
  localparam int REN_BIT  = 18;
  localparam int IVL_LSB  = 19;
  localparam int IVL_W    = 8;
  localparam int DIV_BIT  = 27;
  localparam int CRS_LSB  = 28;
  localparam int CRS_W    = 4;
  localparam int CNT_W    = MRAS_W + 1;

  typedef struct packed {
    logic [CRS_W-1:0]  cas_ras;
    logic              div_hi;
    logic [IVL_W-1:0]  ivl;
    logic              ren;
    logic [MRAS_W-1:0] min_ras;
    logic [PRE_W-1:0]  prech;
  } tcfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_RAS, PH_PRE} phase_t;

  function automatic tcfg_t decode_cfg(input logic [31:0] w);
    tcfg_t c;
    c.cas_ras = w[CRS_LSB +: CRS_W];
    c.div_hi  = w[DIV_BIT];
    c.ivl     = w[IVL_LSB +: IVL_W];
    c.ren     = w[REN_BIT];
    c.min_ras = w[MRAS_LSB +: MRAS_W];
    c.prech   = w[PRE_LSB +: PRE_W];
    return c;
  endfunction
endpackage

// File: rtl/cbr_timer.sv
module cbr_timer #(
  parameter int DIV_LO = 64,
  parameter int DIV_HI = 512,
  parameter int IVL_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             div_hi,
  input  logic [IVL_W-1:0] ivl,
  output logic             expire
);
  localparam int PW = $clog2(DIV_HI);

  logic [PW-1:0]    pre_cnt;
  logic [IVL_W-1:0] iv_cnt;
  logic [PW-1:0]    lim;
  logic             tick;
  logic             wrap;

  assign lim    = div_hi ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
  assign tick   = en && (pre_cnt == lim);
  assign wrap   = ({1'b0, iv_cnt} + (IVL_W+1)'(1)) >= {1'b0, ivl};
  assign expire = tick && (ivl != '0) && wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_cnt <= '0;
      iv_cnt  <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      iv_cnt  <= wrap ? '0 : iv_cnt + IVL_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PW'(1);
    end
  end
endmodule

// File: rtl/cbr_arb.sv
module cbr_arb (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic idle,
  input  logic acc_active,
  output logic pending,
  output logic start
);
  assign start = pending && idle && !acc_active;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= (pending && !start) || expire;
  end
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import cbr_pkg::*;
#(
  parameter int NB       = 4,
  parameter int NVM_BANK = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CRS_W-1:0]  setup,
  input  logic [MRAS_W-1:0] min_ras,
  input  logic [PRE_W-1:0]  prech,
  input  logic [NB-1:0]     bank_en,
  output logic [NB-1:0]     cas,
  output logic [NB-1:0]     ras,
  output logic              busy,
  output logic              idle
);
  localparam logic [NB-1:0] KEEP = ~(NB'(1) << NVM_BANK);

  phase_t           ph;
  logic [CNT_W-1:0] cnt;

  assign busy = (ph != PH_IDLE);
  assign idle = (ph == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
      cas <= '0;
      ras <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_SETUP;
          cnt <= CNT_W'(setup) + CNT_W'(1);
          cas <= bank_en & KEEP;
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_RAS;
          cnt <= CNT_W'(min_ras);
          ras <= cas;
        end else cnt <= cnt - CNT_W'(1);
        PH_RAS: if (cnt == '0) begin
          ph  <= PH_PRE;
          cnt <= CNT_W'(prech);
          ras <= '0;
          cas <= '0;
        end else cnt <= cnt - CNT_W'(1);
        default: if (cnt == '0) ph <= PH_IDLE;
                 else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl
  import cbr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NVM_BANK  = 3,
  parameter int DIV_LO    = 64,
  parameter int DIV_HI    = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          timing_cfg,
  input  logic [NUM_BANKS-1:0] bank_en,
  input  logic                 acc_active,
  output logic [NUM_BANKS-1:0] rfr_cas,
  output logic [NUM_BANKS-1:0] rfr_ras,
  output logic                 rfr_busy,
  output logic                 rfr_pending
);
  logic [31:0] cfg_q;
  tcfg_t       cfg;
  logic        expire, idle, start;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= timing_cfg;
  end

  assign cfg = decode_cfg(cfg_q);

  cbr_timer #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst(rst), .en(cfg.ren), .div_hi(cfg.div_hi),
    .ivl(cfg.ivl), .expire(expire)
  );

  cbr_arb u_arb (
    .clk(clk), .rst(rst), .expire(expire), .idle(idle),
    .acc_active(acc_active), .pending(rfr_pending), .start(start)
  );

  cbr_seq #(.NB(NUM_BANKS), .NVM_BANK(NVM_BANK)) u_seq (
    .clk(clk), .rst(rst), .start(start), .setup(cfg.cas_ras),
    .min_ras(cfg.min_ras), .prech(cfg.prech), .bank_en(bank_en),
    .cas(rfr_cas), .ras(rfr_ras), .busy(rfr_busy), .idle(idle)
  );
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk #(
  parameter int NB       = 4,
  parameter int NVM_BANK = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_active,
  input logic [NB-1:0] rfr_cas,
  input logic [NB-1:0] rfr_ras,
  input logic          rfr_busy,
  input logic          rfr_pending
);
  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (!rfr_busy && !rfr_pending && rfr_cas == '0 && rfr_ras == '0));

  assert_ras_within_cas_R3: assert property (@(posedge clk) disable iff (rst)
    (rfr_ras & ~rfr_cas) == '0);

  assert_ras_after_cas_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(|rfr_ras) |-> $past(|rfr_cas));

  assert_joint_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(|rfr_ras) |-> rfr_cas == '0);

  assert_start_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rfr_busy) |-> !$past(acc_active));

  assert_nvm_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !rfr_cas[NVM_BANK] && !rfr_ras[NVM_BANK]);

  assert_cas_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (|rfr_cas) |-> rfr_busy);
endmodule

bind cbr_refresh_ctrl cbr_refresh_chk #(.NB(NUM_BANKS), .NVM_BANK(NVM_BANK)) u_chk (
  .clk(clk), .rst(rst), .acc_active(acc_active), .rfr_cas(rfr_cas),
  .rfr_ras(rfr_ras), .rfr_busy(rfr_busy), .rfr_pending(rfr_pending)
);

// File: tb/cbr_refresh_ctrl_tb.sv
module cbr_refresh_ctrl_tb;
  localparam int NB = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0]   tcfg = '0;
  logic [NB-1:0] ben  = '0;
  logic          act  = 1'b0;
  logic [NB-1:0] cas, ras;
  logic          busy, pend;

  cbr_refresh_ctrl u_dut (
    .clk(clk), .rst(rst), .timing_cfg(tcfg), .bank_en(ben), .acc_active(act),
    .rfr_cas(cas), .rfr_ras(ras), .rfr_busy(busy), .rfr_pending(pend)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  function automatic logic [31:0] mk(input int en, input int dv, input int ivl,
                                     input int crs, input int mras, input int pre);
    return (32'(crs) << 28) | (32'(dv) << 27) | (32'(ivl) << 19) |
           (32'(en) << 18) | (32'(mras) << 5) | 32'(pre);
  endfunction

  // behavioural reference model
  logic [31:0]   m_cfg;
  int            m_cnt, m_ph, m_left, m_period;
  bit            m_pend, m_st, m_exp;
  logic [NB-1:0] m_mask;

  always @(posedge clk) begin
    if (rst) begin
      m_cfg = '0; m_cnt = 0; m_ph = 0; m_left = 0; m_pend = 0; m_mask = '0;
    end else begin
      m_st = (m_ph == 0) && m_pend && !act;
      m_exp = 0;
      m_period = (m_cfg[27] ? 512 : 64) * int'(m_cfg[26:19]);
      if (!m_cfg[18]) m_cnt = 0;
      else if (m_period != 0 && m_cnt == m_period - 1) begin m_exp = 1; m_cnt = 0; end
      else m_cnt++;
      m_pend = (m_pend && !m_st) || m_exp;
      case (m_ph)
        0: if (m_st) begin m_ph = 1; m_left = int'(m_cfg[31:28]) + 2; m_mask = ben & 4'b0111; end
        1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = int'(m_cfg[9:5]) + 1; end end
        2: begin m_left--; if (m_left == 0) begin m_ph = 3; m_left = int'(m_cfg[4:0]) + 1; end end
        default: begin m_left--; if (m_left == 0) m_ph = 0; end
      endcase
      m_cfg = tcfg;
    end
  end

  // per-clock comparison plus phase-length monitor
  int cyc = 0, last_rise = -1, exp_gap = 0, n_rise = 0;
  int c_setup = 0, c_ras = 0, c_pre = 0;
  logic p_ras = 0, p_busy = 0, p_act = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(cas == (((m_ph == 1) || (m_ph == 2)) ? m_mask : '0), "R3/R4/R7 cas vs model", int'(cas), int'(m_mask));
      chk(ras == ((m_ph == 2) ? m_mask : '0), "R3/R4/R7 ras vs model", int'(ras), int'(m_mask));
      chk(busy == (m_ph != 0), "R5/R9 busy vs model", int'(busy), int'(m_ph != 0));
      chk(pend == m_pend, "R6/R8 pending vs model", int'(pend), int'(m_pend));
      if (|ras) c_ras++;
      if ((|cas) && !(|ras)) c_setup++;
      if (busy && !(|cas)) c_pre++;
      if ((|ras) && !p_ras) begin
        chk(c_setup == int'(tcfg[31:28]) + 2, "R3 CAS-to-RAS delay", c_setup, int'(tcfg[31:28]) + 2);
        chk(ras == (ben & 4'b0111), "R7 refreshed banks", int'(ras), int'(ben & 4'b0111));
        c_setup = 0;
      end
      if (!(|ras) && p_ras) begin
        chk(c_ras == int'(tcfg[9:5]) + 1, "R4 RAS width", c_ras, int'(tcfg[9:5]) + 1);
        chk(cas == '0, "R4 CAS released with RAS", int'(cas), 0);
        c_ras = 0;
      end
      if (!busy && p_busy) begin
        chk(c_pre == int'(tcfg[4:0]) + 1, "R5 precharge length", c_pre, int'(tcfg[4:0]) + 1);
        c_pre = 0;
      end
      if (busy && !p_busy) begin
        n_rise++;
        chk(!p_act, "R6 start with access idle", int'(p_act), 0);
        if (exp_gap != 0 && last_rise >= 0)
          chk(cyc - last_rise == exp_gap, "R1 refresh spacing", cyc - last_rise, exp_gap);
        last_rise = cyc;
      end
    end
    p_ras = |ras; p_busy = busy; p_act = act;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    tcfg[18] = 1'b0;
    exp_gap = 0;
    wait_cyc(120);
    last_rise = -1;
  endtask

  int snap;

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    chk(!busy && !pend && cas == '0 && ras == '0, "R2 reset state", int'({busy, pend, cas, ras}), 0);

    // div 64, interval 2
    ben = 4'b1111;
    tcfg = mk(1, 0, 2, 1, 3, 2);
    exp_gap = 128;
    wait_cyc(700);
    chk(n_rise >= 4, "R1 refreshes with div64", n_rise, 5);

    // disabled: nothing happens
    quiesce();
    snap = n_rise;
    wait_cyc(2000);
    chk(n_rise == snap, "R2 disabled gives no refresh", n_rise, snap);
    chk(!pend, "R2 no pending while disabled", int'(pend), 0);

    // div 512, widest timing fields, bank 3 requested but excluded
    ben = 4'b1011;
    tcfg = mk(1, 1, 1, 15, 31, 31);
    exp_gap = 512;
    snap = n_rise;
    wait_cyc(1600);
    chk(n_rise - snap >= 2, "R1 refreshes with div512", n_rise - snap, 3);

    // interval zero
    quiesce();
    tcfg = mk(1, 0, 0, 0, 0, 0);
    snap = n_rise;
    wait_cyc(1500);
    chk(n_rise == snap, "R1 interval zero gives no refresh", n_rise, snap);

    // coalescing while an access holds the memory
    quiesce();
    ben = 4'b0111;
    act = 1'b1;
    tcfg = mk(1, 0, 1, 0, 0, 0);
    snap = n_rise;
    wait_cyc(400);
    chk(n_rise == snap, "R6 no refresh during access", n_rise, snap);
    chk(pend, "R6 request held pending", int'(pend), 1);
    act = 1'b0;
    wait_cyc(12);
    chk(n_rise == snap + 1, "R8 expiries merge into one refresh", n_rise, snap + 1);
    chk(!pend, "R8 pending cleared after refresh", int'(pend), 0);
    wait_cyc(200);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule